// File: doc/BRIEF.md
# Instrument Status Byte with Service Request

This block forms the top-level status byte of an instrument's status-reporting hierarchy. It folds several lower-level conditions into one byte: an "error log has entries" flag, an "output message ready" flag, and three masked summaries. Each summary is built on the fly from an event vector and its enable vector, one pair each for the questionable, operation and event-status groups. The byte is always visible on a read port.

An 8-bit request-enable mask sits next to the byte. It is loaded through a single-cycle write strobe and read back at any time. The block computes a master summary bit from the enabled status bits. It also emits a one-cycle service-request pulse when any enabled bit changes from 0 to 1. All pins are plain control and status signals. No stream passes through the block, so there is no valid/ready pair and no back-pressure: a write strobe is always taken.

Top module: `instr_svc_status`

## Requirements
- R1: Status bits 1 and 0 always read as 0.
- R2: Status bit 2 equals the error-log-nonempty input in the same cycle.
- R3: Status bit 4 equals the message-available input in the same cycle.
- R4: Status bit 3 is 1 exactly when some questionable event bit and its enable bit are both 1.
- R5: Status bit 5 is 1 exactly when some event-status bit and its enable bit are both 1.
- R6: Status bit 7 is 1 exactly when some operation event bit and its enable bit are both 1.
- R7: Status bit 6 is 1 exactly when some status bit at positions 0 to 5 or 7 is 1 and the same mask bit is 1.
- R8: Mask bit 6 has no effect on status bit 6 or on the request output.
- R9: The request output is high for exactly one cycle. That cycle follows a clock edge at which some enabled status bit (mask bit set, position other than 6) is 1 after being 0 at the previous edge. A bit that stays high raises no further pulse. Several bits rising at the same edge give one pulse.
- R10: When the write strobe is high at a clock edge, all 8 bits of the write data are stored as the mask. The mask read port shows them from the next cycle, including bit 6. Request detection at that same edge still uses the old mask.
- R11: Enabling a status bit that is already 1 raises no request. A later 0-to-1 change of that bit does raise one.
- R12: While reset is low, the mask, the request output and the stored previous status byte are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_nonempty_i | input | 1 | Error log holds at least one entry |
| msg_avail_i | input | 1 | Output message ready to be read |
| evt_bits_i | input | EVT_W | Event-status event bits |
| evt_en_i | input | EVT_W | Event-status enable bits |
| ques_bits_i | input | QUES_W | Questionable event bits |
| ques_en_i | input | QUES_W | Questionable enable bits |
| oper_bits_i | input | OPER_W | Operation event bits |
| oper_en_i | input | OPER_W | Operation enable bits |
| mask_wr_en_i | input | 1 | Load the request-enable mask |
| mask_wr_data_i | input | 8 | New mask value |
| status_o | output | 8 | Status byte |
| mask_o | output | 8 | Current request-enable mask |
| srq_o | output | 1 | Single-cycle service-request pulse |

## Verification
The bench builds the block with QUES_W=4, OPER_W=3 and EVT_W=8. With these narrow groups, a chosen event bit can be placed on or off its enable bit, which exercises each masked summary at both its 0 and 1 outcomes. The full-width event-status group checks the top bit position of a summary. A reference model tracks the previous status byte and the mask. It checks single-cycle pulses, several bits rising at the same edge, the ignored mask bit 6, and enabling a bit that is already high.

// File: rtl/svcstat_pkg.sv
package svcstat_pkg;
  localparam int STB_W    = 8;
  localparam int ERR_POS  = 2;
  localparam int QUES_POS = 3;
  localparam int MAV_POS  = 4;
  localparam int ESB_POS  = 5;
  localparam int MSS_POS  = 6;
  localparam int OPER_POS = 7;
  // positions that may take part in summaries and requests
  localparam logic [STB_W-1:0] MSS_EXCL = ~(STB_W'(1) << MSS_POS);
endpackage

// File: rtl/svcstat_summary.sv
module svcstat_summary #(
  parameter int W = 8
) (
  input  logic [W-1:0] bits_i,
  input  logic [W-1:0] en_i,
  output logic         sum_o
);
  logic [W-1:0] hit;
  generate
    if (W == 1) begin : g_single
      assign hit   = bits_i & en_i;
      assign sum_o = hit[0];
    end else begin : g_multi
      assign hit   = bits_i & en_i;
      assign sum_o = |hit;
    end
  endgenerate
endmodule

// File: rtl/svcstat_mask_reg.sv
module svcstat_mask_reg
  import svcstat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [STB_W-1:0] wr_data_i,
  output logic [STB_W-1:0] mask_o
);
  logic [STB_W-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '0;
    else if (wr_en_i) mask_q <= wr_data_i;
  end

  assign mask_o = mask_q;

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n) wr_en_i |=> (mask_o == $past(wr_data_i))); // R10
endmodule

// File: rtl/svcstat_srq_edge.sv
module svcstat_srq_edge
  import svcstat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [STB_W-1:0] stb_i,
  input  logic [STB_W-1:0] mask_i,
  output logic             srq_o
);
  logic [STB_W-1:0] prev_q;
  logic [STB_W-1:0] eff_mask;
  logic [STB_W-1:0] rise;
  logic             srq_q;
  logic             seen_q;

  assign eff_mask = mask_i & MSS_EXCL;
  assign rise     = stb_i & ~prev_q & eff_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      srq_q  <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      prev_q <= stb_i;
      srq_q  <= |rise;
      seen_q <= 1'b1;
    end
  end

  assign srq_o = srq_q;

  AST_SRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) srq_o |-> $past(|(stb_i & eff_mask))); // R9
  AST_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n) (seen_q && $stable(stb_i)) |=> !srq_o); // R9
endmodule

// File: rtl/instr_svc_status.sv
module instr_svc_status
  import svcstat_pkg::*;
#(
  parameter int QUES_W = 16,
  parameter int OPER_W = 16,
  parameter int EVT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_nonempty_i,
  input  logic              msg_avail_i,
  input  logic [EVT_W-1:0]  evt_bits_i,
  input  logic [EVT_W-1:0]  evt_en_i,
  input  logic [QUES_W-1:0] ques_bits_i,
  input  logic [QUES_W-1:0] ques_en_i,
  input  logic [OPER_W-1:0] oper_bits_i,
  input  logic [OPER_W-1:0] oper_en_i,
  input  logic              mask_wr_en_i,
  input  logic [7:0]        mask_wr_data_i,
  output logic [7:0]        status_o,
  output logic [7:0]        mask_o,
  output logic              srq_o
);
  logic             ques_sum, oper_sum, evt_sum;
  logic [STB_W-1:0] base_stb;
  logic [STB_W-1:0] full_stb;
  logic [STB_W-1:0] mask_w;
  logic             mss;

  svcstat_summary #(.W(QUES_W)) u_ques_sum (.bits_i(ques_bits_i), .en_i(ques_en_i), .sum_o(ques_sum));
  svcstat_summary #(.W(OPER_W)) u_oper_sum (.bits_i(oper_bits_i), .en_i(oper_en_i), .sum_o(oper_sum));
  svcstat_summary #(.W(EVT_W))  u_evt_sum  (.bits_i(evt_bits_i),  .en_i(evt_en_i),  .sum_o(evt_sum));

  svcstat_mask_reg u_mask (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (mask_wr_en_i),
    .wr_data_i (mask_wr_data_i),
    .mask_o    (mask_w)
  );

  always_comb begin
    base_stb           = '0;
    base_stb[ERR_POS]  = err_nonempty_i;
    base_stb[QUES_POS] = ques_sum;
    base_stb[MAV_POS]  = msg_avail_i;
    base_stb[ESB_POS]  = evt_sum;
    base_stb[OPER_POS] = oper_sum;
  end

  assign mss = |(base_stb & mask_w & MSS_EXCL);

  always_comb begin
    full_stb          = base_stb;
    full_stb[MSS_POS] = mss;
  end

  svcstat_srq_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .stb_i  (full_stb),
    .mask_i (mask_w),
    .srq_o  (srq_o)
  );

  assign status_o = full_stb;
  assign mask_o   = mask_w;

  AST_MSS_MATCH: assert property (@(posedge clk) disable iff (!rst_n) status_o[MSS_POS] == |(status_o & mask_o & MSS_EXCL)); // R7
  AST_QUES_MASKED: assert property (@(posedge clk) disable iff (!rst_n) (ques_en_i == '0) |-> !status_o[QUES_POS]); // R4
endmodule

// File: tb/instr_svc_status_bench.sv
module instr_svc_status_bench;
  localparam int QW = 4;
  localparam int OW = 3;
  localparam int EW = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n;
  logic          d_err, d_msg, d_wr;
  logic [EW-1:0] d_ev, d_een;
  logic [QW-1:0] d_q, d_qen;
  logic [OW-1:0] d_o, d_oen;
  logic [7:0]    d_wd;
  logic [7:0]    status_o, mask_o;
  logic          srq_o;

  logic          n_err, n_msg, n_wr;
  logic [EW-1:0] n_ev, n_een;
  logic [QW-1:0] n_q, n_qen;
  logic [OW-1:0] n_o, n_oen;
  logic [7:0]    n_wd;

  logic [7:0] m_mask, m_prev, cur_stat;
  logic       m_srq;

  logic [16:0] exp_q[$];
  string       tag_q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  instr_svc_status #(.QUES_W(QW), .OPER_W(OW), .EVT_W(EW)) u_instr_svc_status (
    .clk(clk), .rst_n(rst_n),
    .err_nonempty_i(d_err), .msg_avail_i(d_msg),
    .evt_bits_i(d_ev), .evt_en_i(d_een),
    .ques_bits_i(d_q), .ques_en_i(d_qen),
    .oper_bits_i(d_o), .oper_en_i(d_oen),
    .mask_wr_en_i(d_wr), .mask_wr_data_i(d_wd),
    .status_o(status_o), .mask_o(mask_o), .srq_o(srq_o)
  );

  function automatic logic [7:0] model_stat(input logic [7:0] mk);
    logic [7:0] s;
    s    = '0;
    s[2] = d_err;
    s[3] = |(d_q & d_qen);
    s[4] = d_msg;
    s[5] = |(d_ev & d_een);
    s[7] = |(d_o & d_oen);
    s[6] = |(s & mk & 8'hBF);
    return s;
  endfunction

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic clear_next();
    n_err = 0; n_msg = 0; n_wr = 0; n_wd = '0;
    n_ev = '0; n_een = '0; n_q = '0; n_qen = '0; n_o = '0; n_oen = '0;
  endtask

  // driver: model the edge just taken, apply the next inputs, push expectation
  task automatic tick(input string tag);
    @(posedge clk); #1;
    m_srq  = |(cur_stat & m_mask & 8'hBF & ~m_prev);
    m_prev = cur_stat;
    if (d_wr) m_mask = d_wd;
    d_err = n_err; d_msg = n_msg; d_wr = n_wr; d_wd = n_wd;
    d_ev = n_ev; d_een = n_een; d_q = n_q; d_qen = n_qen; d_o = n_o; d_oen = n_oen;
    n_wr = 0;
    cur_stat = model_stat(m_mask);
    exp_q.push_back({cur_stat, m_mask, m_srq});
    tag_q.push_back(tag);
  endtask

  // monitor
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [16:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, "status", status_o, e[16:9]);
      chk(t, "mask",   mask_o,   e[8:1]);
      chk(t, "srq",    {7'b0, srq_o}, {7'b0, e[0]});
    end
  end

  initial begin
    #(4 * 5000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    d_err = 0; d_msg = 0; d_wr = 0; d_wd = '0;
    d_ev = '0; d_een = '0; d_q = '0; d_qen = '0; d_o = '0; d_oen = '0;
    clear_next();
    m_mask = '0; m_prev = '0; m_srq = 0; cur_stat = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R12", "reset mask", mask_o, 8'h00);
    chk("R12", "reset srq", {7'b0, srq_o}, 8'h00);
    @(posedge clk); #1;
    rst_n = 1;

    tick("R12");
    n_err = 1; tick("R2");
    n_wr = 1; n_wd = 8'h04; tick("R10");
    tick("R11"); tick("R11");
    n_err = 0; tick("R9");
    n_err = 1; tick("R9"); tick("R9"); tick("R9");
    n_msg = 1; tick("R3");
    n_q = 4'b1010; n_qen = 4'b0101; tick("R4");
    n_qen = 4'b0010; tick("R4");
    n_ev = 8'h80; n_een = 8'h7F; tick("R5");
    n_een = 8'h81; tick("R5");
    n_o = 3'b100; n_oen = 3'b011; tick("R6");
    n_oen = 3'b100; tick("R6");
    tick("R1");
    n_wr = 1; n_wd = 8'h80; tick("R7"); tick("R7");
    n_wr = 1; n_wd = 8'h40; tick("R8");
    clear_next(); tick("R8");
    n_err = 1; n_msg = 1; n_q = 4'b0001; n_qen = 4'b0001; tick("R8"); tick("R8"); tick("R8");
    n_wr = 1; n_wd = 8'h3C; tick("R9");
    clear_next(); tick("R9"); tick("R9");
    n_err = 1; n_msg = 1; n_q = 4'b0100; n_qen = 4'b0100; n_ev = 8'h01; n_een = 8'h01;
    tick("R9"); tick("R9"); tick("R9");
    n_wr = 1; n_wd = 8'h5A; tick("R10"); tick("R10"); tick("R10");

    wait (exp_q.size() == 0);
    @(posedge clk); #1;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule